// File: doc/BRIEF.md
# Counted-Loop Sequencer

This controller repeats a fixed body of work steps a programmable number of times. It waits in idle for a start strobe. The strobe comes from another clock domain, so it passes through a two-flop synchronizer first. When the synchronized strobe is seen, the controller captures a loop count from the low bits of a wide command word and clears its pass counter. It then walks a chain of body steps, one per clock, and raises one strobe for each step. The datapath work hangs off those strobes.

After the last body step the pass counter advances. A separate compare cycle then decides whether to run the body again or to finish. On finishing, one output cycle raises `done`, and the controller returns to idle. The pass counter is a plain register. It is loaded from a clear, hold or increment choice made by the current state, so no adder sits in a combinational loop. A count of zero gives exactly one pass.

Top module: `loop_sequencer`

## Requirements
- R1: While reset is high, and at the first sample after reset is released, `busy`, `done` and every bit of `body_step` are 0.
- R2: `sync_in` passes through a two-flop synchronizer. If `sync_in` rises before rising edge k, `busy` is first high after edge k+2.
- R3: During a run the body steps follow in order `body_step[0]` to `body_step[BODY_STATES-1]`. At most one bit is high, each for exactly one cycle. After the last body step there is one compare cycle with `body_step` all zero.
- R4: The loop count is bits `[CNT_W-1:0]` of `cmd_word`, captured on the start cycle. A count N from 1 to 2^CNT_W-1 gives exactly N body passes. Bits above `CNT_W-1` have no effect.
- R5: A captured count of zero gives exactly one body pass.
- R6: `done` is high for exactly one cycle. That cycle is the last busy cycle, it follows the final compare cycle, and `body_step` is zero during it.
- R7: Changes on `cmd_word` after the start cycle do not change the number of passes of the run in progress.
- R8: A `sync_in` pulse while `busy` is high is ignored. The run is not restarted or lengthened, and no new run starts after it. A pulse seen in idle starts a new run.
- R9: A run of N passes keeps `busy` high for N*(BODY_STATES+1)+1 cycles.
- R10: Raising reset in the middle of a run clears `busy`, `done` and `body_step` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| sync_in | input | 1 | Start strobe from another clock domain |
| cmd_word | input | WORD_W | Command word; its low CNT_W bits are the loop count |
| busy | output | 1 | High in every state except idle |
| done | output | 1 | One-cycle pulse in the output state |
| body_step | output | BODY_STATES | One-hot strobe for the current body step |

## Verification
The bench keeps the default body length of nine steps and the 36-bit command word. It builds the block with `CNT_W` = 6 instead of 20. With a 6-bit count, the all-ones count of 63 passes finishes in a few hundred cycles, so the largest count and the pass-counter match at its top value can be tested directly. The ignored upper bits of the word also become wide enough to fill with a distinctive pattern. Zero count, mid-run word and strobe changes, and asynchronous reset during a run are each driven in their own scenario.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BODY = 2'd1,
    PH_CMP  = 2'd2,
    PH_OUT  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_INC   = 2'd2
  } cnt_op_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/iter_counter.sv
module iter_counter
  import loop_seq_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_t          op,
  input  logic [CNT_W-1:0] load_val,
  output logic             match
);
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] pass_q;
  logic [CNT_W-1:0] pass_d;
  logic [CNT_W-1:0] limit_d;

  // Zero count means one pass.
  function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  always_comb begin
    pass_d  = pass_q;
    limit_d = limit_q;
    case (op)
      CNT_CLEAR: begin
        pass_d  = '0;
        limit_d = load_val;
      end
      CNT_INC:  pass_d = pass_q + CNT_W'(1);
      default:  pass_d = pass_q;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pass_q  <= '0;
      limit_q <= '0;
    end else begin
      pass_q  <= pass_d;
      limit_q <= limit_d;
    end
  end

  assign match = (pass_q == eff_limit(limit_q));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (op == CNT_HOLD) |=> ($stable(pass_q) && $stable(limit_q)));

  assert_inc_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    (op == CNT_INC) |=> (pass_q == $past(pass_q) + CNT_W'(1)));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (op == CNT_CLEAR) |=> (pass_q == '0));
endmodule

// File: rtl/loop_fsm.sv
module loop_fsm
  import loop_seq_pkg::*;
#(
  parameter int BODY_STATES = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   match,
  output cnt_op_t                cnt_op,
  output logic                   busy,
  output logic                   done,
  output logic [BODY_STATES-1:0] body_step
);
  localparam int IDX_W = (BODY_STATES > 1) ? $clog2(BODY_STATES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BODY_STATES - 1);

  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    phase_d = PH_IDLE;
    idx_d   = '0;
    cnt_op  = CNT_HOLD;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_BODY;
          cnt_op  = CNT_CLEAR;
        end
      end
      PH_BODY: begin
        if (idx_q == LAST) begin
          phase_d = PH_CMP;
          cnt_op  = CNT_INC;
        end else if (idx_q < LAST) begin
          phase_d = PH_BODY;
          idx_d   = idx_q + IDX_W'(1);
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_CMP:  phase_d = match ? PH_OUT : PH_BODY;
      PH_OUT:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign done = (phase_q == PH_OUT);

  for (genvar i = 0; i < BODY_STATES; i++) begin : g_step
    assign body_step[i] = (phase_q == PH_BODY) && (idx_q == IDX_W'(i));
  end

  assert_last_to_cmp_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_BODY && idx_q == LAST) |=> (phase_q == PH_CMP));

  assert_out_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OUT) |=> (phase_q == PH_IDLE && !done));

  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_BODY && idx_q != '0) |-> $stable(cnt_op == CNT_CLEAR));
endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
  import loop_seq_pkg::*;
#(
  parameter int WORD_W      = 36,
  parameter int CNT_W       = 20,
  parameter int BODY_STATES = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sync_in,
  input  logic [WORD_W-1:0]      cmd_word,
  output logic                   busy,
  output logic                   done,
  output logic [BODY_STATES-1:0] body_step
);
  logic    start_seen;
  logic    count_match;
  cnt_op_t count_op;

  sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (start_seen)
  );

  iter_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .op       (count_op),
    .load_val (cmd_word[CNT_W-1:0]),
    .match    (count_match)
  );

  loop_fsm #(.BODY_STATES(BODY_STATES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start_seen),
    .match     (count_match),
    .cnt_op    (count_op),
    .busy      (busy),
    .done      (done),
    .body_step (body_step)
  );

  assert_step_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(body_step));

  assert_start_from_sync_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_seen));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (body_step == '0 && busy));
endmodule

// File: tb/loop_sequencer_bench.sv
module loop_sequencer_bench;
  localparam int WORD_W = 36;
  localparam int CNT_W  = 6;
  localparam int BODY   = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sync_in = 1'b0;
  logic [WORD_W-1:0] cmd_word = '0;
  logic              busy, done;
  logic [BODY-1:0]   body_step;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  loop_sequencer #(.WORD_W(WORD_W), .CNT_W(CNT_W), .BODY_STATES(BODY)) u_loop_sequencer (
    .clk(clk), .rst(rst), .sync_in(sync_in), .cmd_word(cmd_word),
    .busy(busy), .done(done), .body_step(body_step)
  );

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a run and follows it to idle, recording what it sees.
  task automatic run(input logic [WORD_W-1:0] w, input logic [WORD_W-1:0] alt,
                     input bit disturb, output int lat, output int passes,
                     output int busy_n, output int done_n, output int bad);
    cmd_word = w;
    sync_in  = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    lat = 1;
    while (!busy && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    passes = 0; busy_n = 0; done_n = 0; bad = 0;
    while (busy && busy_n < 5000) begin
      if (done) begin
        done_n++;
        if (body_step != '0 || busy_n % (BODY + 1) != 0) bad++;
      end else begin
        int p = busy_n % (BODY + 1);
        logic [BODY-1:0] ev = (p < BODY) ? (BODY'(1) << p) : '0;
        if (body_step != ev) bad++;
      end
      if (body_step[0]) passes++;
      if (disturb && busy_n == 4) begin
        cmd_word = alt;
        sync_in  = 1'b1;
      end
      if (disturb && busy_n == 5) sync_in = 1'b0;
      busy_n++;
      @(negedge clk);
    end
    if (done || body_step != '0) bad++;
  endtask

  task automatic expect_run(input string tag, input logic [WORD_W-1:0] w, input int n);
    int lat, passes, busy_n, done_n, bad;
    run(w, '0, 1'b0, lat, passes, busy_n, done_n, bad);
    chk({tag, " R2 start latency"}, lat == 3, lat, 3);
    chk({tag, " R4 passes"}, passes == n, passes, n);
    chk({tag, " R9 busy length"}, busy_n == n * (BODY + 1) + 1, busy_n, n * (BODY + 1) + 1);
    chk({tag, " R6 done count"}, done_n == 1, done_n, 1);
    chk({tag, " R3 step order"}, bad == 0, bad, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 in reset", !busy && !done && body_step == '0, {busy, done}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", !busy && !done && body_step == '0, {busy, done}, 0);
  endtask

  task automatic t_zero();
    int lat, passes, busy_n, done_n, bad;
    run({30'h0, 6'd0}, '0, 1'b0, lat, passes, busy_n, done_n, bad);
    chk("R5 zero count passes", passes == 1, passes, 1);
    chk("R5 zero count length", busy_n == BODY + 2, busy_n, BODY + 2);
  endtask

  task automatic t_disturb();
    int lat, passes, busy_n, done_n, bad, idle_busy;
    run({30'h0, 6'd3}, {30'h0, 6'd40}, 1'b1, lat, passes, busy_n, done_n, bad);
    chk("R7 word change ignored", passes == 3, passes, 3);
    chk("R8 sync in run no restart", busy_n == 31, busy_n, 31);
    idle_busy = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy) idle_busy++;
    end
    chk("R8 no run after busy sync", idle_busy == 0, idle_busy, 0);
  endtask

  task automatic t_midreset();
    int lat;
    cmd_word = {30'h0, 6'd4};
    sync_in  = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    lat = 0;
    while (!busy && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    repeat (4) @(negedge clk);
    chk("R10 running before reset", busy && body_step != '0, busy, 1);
    rst = 1'b1;
    #1;
    chk("R10 async clear", !busy && !done && body_step == '0, {busy, done}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    expect_run("single", {30'h0, 6'd1}, 1);
    expect_run("upper bits set R4", {30'h2AAAAAAA, 6'd5}, 5);
    t_zero();
    expect_run("max count", {30'h0, 6'h3F}, 63);
    t_disturb();
    expect_run("rerun after idle R8", {30'h0, 6'd2}, 2);
    t_midreset();
    expect_run("after reset", {30'h0, 6'd1}, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule